// File: doc/BRIEF.md
# Split-Transaction Back-Pointer Sequencer

This block is the control sequencer a high-speed USB host uses when it walks a full/low-speed isochronous IN split descriptor whose complete-split phase wraps across a frame boundary. It receives the current descriptor's state, the one-hot microframe bit and the descriptor's address. From these it decides whether the previous frame's descriptor must finish its complete-split first. If so, it saves the current descriptor and makes one hop through the back-pointer link. It reads the earlier descriptor, advances or retires it, and writes it back. It then either continues through that descriptor's next pointer or resumes the saved descriptor.

Jobs enter on a valid/ready handshake. The sequencer takes a new job only while idle, so `job_ready` low holds the job at the source. Descriptor memory is reached through a single request port with the same rules. A request (`mem_valid` with `mem_we`, `mem_addr`, `mem_wdata`) stays unchanged until `mem_ready` is seen high at a clock edge. Read data is taken from `mem_rdata` on that same edge. The outcome comes back as a one-cycle `done` pulse with a result code, a pointer and the current descriptor's resulting state. Packet transmission, byte buffers and the two eligibility tests are outside the block. The tests arrive as the flags `test_a` and `test_b`.

Descriptor layout (the `sitd_t` struct, MSB first):
- active
- do_cs (1 = do complete-split, 0 = do start-split)
- missed
- smask0
- back_t
- prog[5:0]
- next_ptr[15:0]
- back_ptr[15:0]

Result codes:
- 0 = continue
- 1 = advance via the previous descriptor's next pointer
- 2 = start a split on the current descriptor

Top module: `bp_seq`

## Requirements
- R1: After a synchronous active-high reset, `done` and `mem_valid` are 0, `job_ready` is 1, and the saved descriptor register is cleared.
- R2: An accepted job that does not meet R3 produces no memory request. It produces `done` one cycle after acceptance, with code 0 (continue), `done_ptr` = `job_addr`, and `done_desc` equal to the job descriptor.
- R3: A job whose descriptor has active=1 and do_cs=1 takes the hop when either of two conditions holds. The first is `job_uf` = 0x01 with back_t = 0. The second is `job_uf` = 0x02 with smask0 = 0. The hop issues a read request (`mem_we` = 0) at the descriptor's back_ptr.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged on the next cycle.
- R5: If the previous descriptor is active with do_cs=1 and both tests are 1, it is written back at the back_ptr address. The written copy has prog+1 and active = NOT `cs_finish`. If it stays active, `done` reports code 1 with `done_ptr` = its next_ptr, and the current descriptor is left unchanged.
- R6: If the previous descriptor is active with do_cs=1 and either test is 0, nothing is written. `done` reports code 1 with its next_ptr.
- R7: If the previous descriptor is active with do_cs=0, it is written back with active=0 and missed=1, and the current descriptor is then resumed as in R8.
- R8: When the previous descriptor is, or becomes, inactive, the saved current descriptor is written to `job_addr` with do_cs=0. `done` then reports `done_ptr` = `job_addr`. The code is 2 if `job_uf` = 0x01 and smask0 = 1, and 0 otherwise.
- R9: At most one read is issued per job; the previous descriptor's own back pointer is never followed.
- R10: `job_ready` is 1 only when no memory request is pending. `done` may coincide with acceptance of the next job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_valid | input | 1 | New descriptor job offered |
| job_ready | output | 1 | Sequencer idle and taking a job |
| job_desc | input | 43 | Current descriptor state (`sitd_t`) |
| job_addr | input | 16 | Current descriptor address |
| job_uf | input | 8 | One-hot microframe bit |
| test_a | input | 1 | First complete-split eligibility flag |
| test_b | input | 1 | Second complete-split eligibility flag |
| cs_finish | input | 1 | Complete-split result ends the transfer |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Descriptor address |
| mem_wdata | output | 43 | Write data |
| mem_rdata | input | 43 | Read data, valid with `mem_ready` on a read |
| done | output | 1 | One-cycle outcome pulse |
| done_code | output | 2 | 0 continue, 1 advance, 2 start split |
| done_ptr | output | 16 | Next item address, or the current descriptor address |
| done_desc | output | 43 | Resulting state of the current descriptor |

## Verification
The `done` pulse that closes one job and the acceptance of the next job can fall in the same cycle. The sequencer returns to idle on the edge that emits `done`. To provoke this, the bench presents a second job while the final write-back of a hop is still unacknowledged. It then acknowledges the write and holds the job valid. The bench judges the overlap by requiring that the first pulse carries the first job's result. The following cycle must carry a fresh pulse with the second job's pointer and code, and no stray memory request may appear in between.

// File: rtl/bp_seq_pkg.sv
package bp_seq_pkg;
  parameter int ADDR_W = 16;
  parameter int PROG_W = 6;
  parameter int UF_W   = 8;

  typedef struct packed {
    logic              active;
    logic              do_cs;
    logic              missed;
    logic              smask0;
    logic              back_t;
    logic [PROG_W-1:0] prog;
    logic [ADDR_W-1:0] next_ptr;
    logic [ADDR_W-1:0] back_ptr;
  } sitd_t;

  localparam int DESC_W = $bits(sitd_t);

  typedef enum logic [1:0] {
    RES_CONT   = 2'd0,
    RES_ADV    = 2'd1,
    RES_SSPLIT = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_PREV,
    ST_EVAL,
    ST_WR_PREV,
    ST_WR_CUR
  } st_e;
endpackage

// File: rtl/bp_hop_decide.sv
module bp_hop_decide
  import bp_seq_pkg::*;
#(
  parameter int UFW = UF_W
) (
  input  sitd_t          cur,
  input  logic [UFW-1:0] uf,
  output logic           take_hop
);
  localparam logic [UFW-1:0] UF_FIRST  = UFW'(1);
  localparam logic [UFW-1:0] UF_SECOND = UFW'(2);

  logic eligible;
  logic wrap_first;
  logic wrap_second;

  always_comb begin
    eligible    = cur.active && cur.do_cs;
    wrap_first  = (uf == UF_FIRST)  && !cur.back_t;
    wrap_second = (uf == UF_SECOND) && !cur.smask0;
    take_hop    = eligible && (wrap_first || wrap_second);
  end
endmodule

// File: rtl/bp_prev_advance.sv
module bp_prev_advance
  import bp_seq_pkg::*;
(
  input  sitd_t prev,
  input  logic  test_a,
  input  logic  test_b,
  input  logic  cs_finish,
  output logic  wr_en,
  output sitd_t upd
);
  always_comb begin
    upd   = prev;
    wr_en = 1'b0;
    if (prev.active) begin
      if (prev.do_cs) begin
        if (test_a && test_b) begin
          wr_en      = 1'b1;
          upd.prog   = prev.prog + PROG_W'(1);
          upd.active = !cs_finish;
        end
      end else begin
        wr_en      = 1'b1;
        upd.active = 1'b0;
        upd.missed = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bp_mem_req.sv
module bp_mem_req #(
  parameter int AW = 16,
  parameter int DW = 43
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          ready,
  output logic          valid,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          fire
);
  assign fire = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (load) begin
      valid <= 1'b1;
      we    <= load_we;
      addr  <= load_addr;
      wdata <= load_data;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bp_seq.sv
module bp_seq
  import bp_seq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int UFW = UF_W,
  parameter int DW  = DESC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           job_valid,
  output logic           job_ready,
  input  logic [DW-1:0]  job_desc,
  input  logic [AW-1:0]  job_addr,
  input  logic [UFW-1:0] job_uf,
  input  logic           test_a,
  input  logic           test_b,
  input  logic           cs_finish,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done,
  output logic [1:0]     done_code,
  output logic [AW-1:0]  done_ptr,
  output logic [DW-1:0]  done_desc
);
  localparam logic [UFW-1:0] UF_FIRST = UFW'(1);

  st_e          st_q;
  sitd_t        cur_q;
  sitd_t        prev_q;
  logic [AW-1:0] cur_addr_q;
  logic [UFW-1:0] uf_q;

  sitd_t        job_s;
  sitd_t        resumed;
  sitd_t        prev_upd;
  logic         take_hop;
  logic         prev_wr;
  logic         accept;
  logic         fire;
  logic         resume;

  logic          ld;
  logic          ld_we;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  assign job_s     = sitd_t'(job_desc);
  assign job_ready = (st_q == ST_IDLE);
  assign accept    = job_valid && job_ready;

  always_comb begin
    resumed       = cur_q;
    resumed.do_cs = 1'b0;
  end

  bp_hop_decide #(.UFW(UFW)) u_hop (
    .cur      (job_s),
    .uf       (job_uf),
    .take_hop (take_hop)
  );

  bp_prev_advance u_adv (
    .prev      (prev_q),
    .test_a    (test_a),
    .test_b    (test_b),
    .cs_finish (cs_finish),
    .wr_en     (prev_wr),
    .upd       (prev_upd)
  );

  // resume the saved descriptor once the previous one is inactive
  always_comb begin
    resume = 1'b0;
    if (st_q == ST_EVAL && !prev_wr && !prev_q.active) resume = 1'b1;
    if (st_q == ST_WR_PREV && fire && !prev_q.active)  resume = 1'b1;
  end

  always_comb begin
    ld      = 1'b0;
    ld_we   = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    if (accept && take_hop) begin
      ld      = 1'b1;
      ld_addr = job_s.back_ptr;
    end else if (st_q == ST_EVAL && prev_wr) begin
      ld      = 1'b1;
      ld_we   = 1'b1;
      ld_addr = cur_q.back_ptr;
      ld_data = DW'(prev_upd);
    end else if (resume) begin
      ld      = 1'b1;
      ld_we   = 1'b1;
      ld_addr = cur_addr_q;
      ld_data = DW'(resumed);
    end
  end

  bp_mem_req #(.AW(AW), .DW(DW)) u_req (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .load_we   (ld_we),
    .load_addr (ld_addr),
    .load_data (ld_data),
    .ready     (mem_ready),
    .valid     (mem_valid),
    .we        (mem_we),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .fire      (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cur_q      <= '0;
      prev_q     <= '0;
      cur_addr_q <= '0;
      uf_q       <= '0;
      done       <= 1'b0;
      done_code  <= RES_CONT;
      done_ptr   <= '0;
      done_desc  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            cur_q      <= job_s;
            cur_addr_q <= job_addr;
            uf_q       <= job_uf;
            if (take_hop) begin
              st_q <= ST_RD_PREV;
            end else begin
              done      <= 1'b1;
              done_code <= RES_CONT;
              done_ptr  <= job_addr;
              done_desc <= job_desc;
            end
          end
        end
        ST_RD_PREV: begin
          if (fire) begin
            prev_q <= sitd_t'(mem_rdata);
            st_q   <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (prev_wr) begin
            prev_q <= prev_upd;
            st_q   <= ST_WR_PREV;
          end else if (prev_q.active) begin
            done      <= 1'b1;
            done_code <= RES_ADV;
            done_ptr  <= prev_q.next_ptr;
            done_desc <= DW'(cur_q);
            st_q      <= ST_IDLE;
          end else begin
            cur_q <= resumed;
            st_q  <= ST_WR_CUR;
          end
        end
        ST_WR_PREV: begin
          if (fire) begin
            if (prev_q.active) begin
              done      <= 1'b1;
              done_code <= RES_ADV;
              done_ptr  <= prev_q.next_ptr;
              done_desc <= DW'(cur_q);
              st_q      <= ST_IDLE;
            end else begin
              cur_q <= resumed;
              st_q  <= ST_WR_CUR;
            end
          end
        end
        ST_WR_CUR: begin
          if (fire) begin
            done      <= 1'b1;
            done_code <= (uf_q == UF_FIRST && cur_q.smask0) ? RES_SSPLIT : RES_CONT;
            done_ptr  <= cur_addr_q;
            done_desc <= DW'(cur_q);
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bp_seq_chk.sv
module bp_seq_chk
  import bp_seq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int UFW = UF_W,
  parameter int DW  = DESC_W
) (
  input logic           clk,
  input logic           rst,
  input logic           job_valid,
  input logic           job_ready,
  input logic [DW-1:0]  job_desc,
  input logic [UFW-1:0] job_uf,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           done,
  input logic [1:0]     done_code
);
  sitd_t jd;
  logic  hop_exp;
  logic  rd_seen;

  assign jd = sitd_t'(job_desc);
  assign hop_exp = jd.active && jd.do_cs &&
                   ((job_uf == UFW'(1) && !jd.back_t) || (job_uf == UFW'(2) && !jd.smask0));

  always_ff @(posedge clk) begin
    if (rst) rd_seen <= 1'b0;
    else if (job_valid && job_ready) rd_seen <= 1'b0;
    else if (mem_valid && mem_ready && !mem_we) rd_seen <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !mem_valid && job_ready));

  p_no_hop_r2: assert property (@(posedge clk) disable iff (rst)
    (job_valid && job_ready && !hop_exp) |=> (done && done_code == 2'd0 && !mem_valid));

  p_hop_read_r3: assert property (@(posedge clk) disable iff (rst)
    (job_valid && job_ready && hop_exp) |=> (mem_valid && !mem_we && mem_addr == jd.back_ptr));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_single_hop_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_we) |-> !rd_seen);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
    job_ready |-> !mem_valid);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> job_ready);
endmodule

bind bp_seq bp_seq_chk #(.AW(AW), .UFW(UFW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .job_valid (job_valid),
  .job_ready (job_ready),
  .job_desc  (job_desc),
  .job_uf    (job_uf),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .done_code (done_code)
);

// File: tb/sim_bp_seq.sv
module sim_bp_seq;
  import bp_seq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = DESC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic job_valid = 1'b0;
  logic job_ready;
  logic [DW-1:0] job_desc = '0;
  logic [ADDR_W-1:0] job_addr = '0;
  logic [UF_W-1:0] job_uf = '0;
  logic test_a = 1'b0, test_b = 1'b0, cs_finish = 1'b0;
  logic mem_valid, mem_we;
  logic mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic done;
  logic [1:0] done_code;
  logic [ADDR_W-1:0] done_ptr;
  logic [DW-1:0] done_desc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_seq u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic sitd_t mk(input bit act, input bit cs, input bit sm0, input bit bt,
                               input logic [15:0] nxt, input logic [15:0] bp);
    sitd_t d;
    d = '0;
    d.active = act; d.do_cs = cs; d.smask0 = sm0; d.back_t = bt;
    d.prog = 6'd3; d.next_ptr = nxt; d.back_ptr = bp;
    return d;
  endfunction

  task automatic give_job(input sitd_t d, input logic [15:0] a, input logic [7:0] uf);
    job_desc = DW'(d); job_addr = a; job_uf = uf; job_valid = 1'b1;
    @(negedge clk);
    job_valid = 1'b0;
  endtask

  // wait for a request, check it, hold it unacknowledged, then acknowledge
  task automatic serve(input bit we, input logic [15:0] addr, input sitd_t wd,
                       input int delay, input sitd_t rd, input string tag);
    int n;
    n = 0;
    while (!mem_valid && n < 20) begin @(negedge clk); n++; end
    chk(mem_valid, tag, 64'(mem_valid), 64'd1);
    chk(mem_we == we && mem_addr == addr, tag, {mem_we, 47'd0, mem_addr}, {we, 47'd0, addr});
    if (we) chk(mem_wdata == DW'(wd), tag, 64'(mem_wdata), 64'(wd));
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(mem_valid && mem_we == we && mem_addr == addr, {tag, " R4 hold"},
          {mem_valid, 47'd0, mem_addr}, {1'b1, 47'd0, addr});
    end
    mem_rdata = DW'(rd); mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic expect_done(input logic [1:0] code, input logic [15:0] ptr, input string tag);
    int n;
    bit stray;
    n = 0; stray = 0;
    while (!done && n < 20) begin
      if (mem_valid) stray = 1;
      @(negedge clk); n++;
    end
    chk(done && !stray && !mem_valid, tag, {done, stray, 62'd0}, {1'b1, 63'd0});
    chk(done_code == code && done_ptr == ptr, tag, {done_code, 46'd0, done_ptr}, {code, 46'd0, ptr});
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!done && !mem_valid && job_ready, "R1 reset", {done, mem_valid, job_ready}, 64'd1);
  endtask

  task automatic t_nohop;
    sitd_t d;
    d = mk(1'b0, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0200);
    give_job(d, 16'h0010, 8'h01);
    chk(done && done_code == 2'd0 && done_ptr == 16'h0010 && done_desc == DW'(d) && !mem_valid,
        "R2 inactive", {done_code, done_ptr}, {2'd0, 16'h0010});
    @(negedge clk);
    d = mk(1'b1, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0200);
    give_job(d, 16'h0011, 8'h04);
    chk(done && done_code == 2'd0 && !mem_valid, "R2 other uframe", 64'(done), 64'd1);
    @(negedge clk);
    d = mk(1'b1, 1'b1, 1'b0, 1'b1, 16'h0100, 16'h0200);
    give_job(d, 16'h0012, 8'h01);
    chk(done && !mem_valid, "R3 terminate bit set blocks hop", 64'(mem_valid), 64'd0);
    @(negedge clk);
    d = mk(1'b1, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h0200);
    give_job(d, 16'h0013, 8'h02);
    chk(done && !mem_valid, "R3 smask0 set blocks second-uframe hop", 64'(mem_valid), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_prev_stays;
    sitd_t c, p, w;
    test_a = 1; test_b = 1; cs_finish = 0;
    c = mk(1'b1, 1'b1, 1'b0, 1'b0, 16'h0111, 16'h0300);
    p = mk(1'b1, 1'b1, 1'b0, 1'b0, 16'h0400, 16'h0500);
    w = p; w.prog = p.prog + 1;
    give_job(c, 16'h0020, 8'h01);
    serve(1'b0, 16'h0300, '0, 3, p, "R3 hop read");
    serve(1'b1, 16'h0300, w, 2, '0, "R5 prev writeback");
    expect_done(2'd1, 16'h0400, "R5 advance via next, R9 single read");
  endtask

  task automatic t_prev_finishes;
    sitd_t c, p, w, r;
    test_a = 1; test_b = 1; cs_finish = 1;
    c = mk(1'b1, 1'b1, 1'b1, 1'b0, 16'h0111, 16'h0310);
    p = mk(1'b1, 1'b1, 1'b0, 1'b0, 16'h0410, 16'h0510);
    w = p; w.prog = p.prog + 1; w.active = 1'b0;
    r = c; r.do_cs = 1'b0;
    give_job(c, 16'h0030, 8'h01);
    serve(1'b0, 16'h0310, '0, 0, p, "R3 read");
    serve(1'b1, 16'h0310, w, 1, '0, "R5 finished writeback");
    serve(1'b1, 16'h0030, r, 0, '0, "R8 resume write");
    chk(done && done_code == 2'd2 && done_ptr == 16'h0030, "R8 start split",
        {done_code, done_ptr}, {2'd2, 16'h0030});
    @(negedge clk);
  endtask

  task automatic t_tests_fail;
    sitd_t c, p;
    test_a = 1; test_b = 0; cs_finish = 0;
    c = mk(1'b1, 1'b1, 1'b0, 1'b1, 16'h0111, 16'h0320);
    p = mk(1'b1, 1'b1, 1'b0, 1'b0, 16'h0420, 16'h0520);
    give_job(c, 16'h0040, 8'h02);
    serve(1'b0, 16'h0320, '0, 1, p, "R3 second-uframe read");
    expect_done(2'd1, 16'h0420, "R6 no write on failed test");
  endtask

  task automatic t_prev_start;
    sitd_t c, p, w, r;
    test_a = 1; test_b = 1; cs_finish = 0;
    c = mk(1'b1, 1'b1, 1'b0, 1'b1, 16'h0111, 16'h0330);
    p = mk(1'b1, 1'b0, 1'b0, 1'b0, 16'h0430, 16'h0530);
    w = p; w.active = 1'b0; w.missed = 1'b1;
    r = c; r.do_cs = 1'b0;
    give_job(c, 16'h0050, 8'h02);
    serve(1'b0, 16'h0330, '0, 0, p, "R3 read");
    serve(1'b1, 16'h0330, w, 0, '0, "R7 missed writeback");
    serve(1'b1, 16'h0050, r, 0, '0, "R8 resume write");
    chk(done && done_code == 2'd0 && done_ptr == 16'h0050 && done_desc == DW'(r),
        "R8 continue on second uframe", {done_code, done_ptr}, {2'd0, 16'h0050});
    @(negedge clk);
  endtask

  task automatic t_overlap;
    sitd_t c, p, r, c2;
    int n;
    c = mk(1'b1, 1'b1, 1'b0, 1'b0, 16'h0111, 16'h0340);
    p = mk(1'b0, 1'b1, 1'b0, 1'b0, 16'h0440, 16'h0540);
    r = c; r.do_cs = 1'b0;
    c2 = mk(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    give_job(c, 16'h0060, 8'h01);
    serve(1'b0, 16'h0340, '0, 0, p, "R3 read");
    n = 0;
    while (!mem_valid && n < 20) begin @(negedge clk); n++; end
    chk(mem_we && mem_addr == 16'h0060 && mem_wdata == DW'(r), "R8 inactive prev resume",
        {mem_we, 47'd0, mem_addr}, {1'b1, 47'd0, 16'h0060});
    chk(!job_ready, "R10 busy not ready", 64'(job_ready), 64'd0);
    mem_ready = 1'b1;
    job_desc = DW'(c2); job_addr = 16'h0070; job_uf = 8'h01; job_valid = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(done && done_code == 2'd0 && done_ptr == 16'h0060 && job_ready, "R10 first done",
        {done_code, done_ptr}, {2'd0, 16'h0060});
    @(negedge clk);
    job_valid = 1'b0;
    chk(done && done_code == 2'd0 && done_ptr == 16'h0070 && !mem_valid, "R10 overlapped job done",
        {done_code, done_ptr}, {2'd0, 16'h0070});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nohop();
    t_prev_stays();
    t_prev_finishes();
    t_tests_fail();
    t_prev_start();
    t_overlap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule